// File: doc/BRIEF.md
# NAND Page ECC Bus Observer

This block computes a Hamming parity word over one NAND page while that page moves across the external memory bus. It takes no data stream and drives nothing on the bus. It watches the chip-enable line, the write strobe, the read strobe and the 16-bit data lines. Each completed strobe while the chip is selected adds one bus beat to the running code. The code corrects any single flipped bit in the page and detects any two flipped bits.

Software picks a page size and a bus width, then raises the enable. When the configured number of bytes has been seen, the block freezes. It raises a done flag and holds the parity word steady until software reads it. Dropping the enable clears the word and the byte count. Raising the enable again starts a fresh page.

The bus is observed passively, so there is no valid/ready pair and no back-pressure. A beat that the block cannot use is simply not counted. All control and status pins are plain levels.

Top module: `nes_ecc_snoop`

## Requirements
- R1: A beat is taken on the clock edge where `bus_we_n` or `bus_re_n` is first seen high after being low, provided `bus_ce_n` is low at that edge. `bus_data` is sampled at that same edge.
- R2: A strobe edge seen while `bus_ce_n` is high adds nothing to the code or to the byte count.
- R3: `ctl_size` values 0 to 5 select pages of 256, 512, 1024, 2048, 4096 and 8192 bytes. Values 6 and 7 select 8192 bytes. For a page of 2^L bytes, every `ecc_value` bit at or above position 2L+6 reads zero.
- R4: `ecc_done` stays low until the page's byte count is reached. It rises in the cycle after the final beat's edge and stays high while the enable and size are held.
- R5: After `ecc_done` is high, further beats leave `ecc_value` unchanged until the block is re-enabled.
- R6: While `ctl_en` is low, `ecc_value` and `ecc_done` are zero after the next clock edge, and the count restarts when the enable returns. Both outputs are zero after reset.
- R7: Bits [5:0] hold column parity. For each j in 0 to 2:
  - bit 2j is the XOR of all data bits whose bit index within the byte has bit j clear;
  - bit 2j+1 is the XOR of all data bits whose bit index has bit j set.
- R8: Bits from 6 upward hold line parity. For each address bit k below L:
  - bit 6+2k is the XOR of the parities of all bytes whose address has bit k clear;
  - bit 7+2k is the XOR of the parities of all bytes whose address has bit k set.
- R9: With `ctl_wide` high, each beat counts as two bytes. `bus_data[7:0]` is taken at the lower address and `bus_data[15:8]` at the next. With `ctl_wide` low, only `bus_data[7:0]` is used and each beat counts as one byte.
- R10: XOR a stored code with a recomputed code to get a syndrome.
  - If exactly one bit of every parity pair is set, the error is a single correctable one. The odd line bits give its byte address and the odd column bits give its bit position.
  - Any other nonzero syndrome that is not a single set bit means two or more data bits are wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Calculation enable; low clears the result |
| ctl_size | input | 3 | Page size code |
| ctl_wide | input | 1 | High: 16-bit bus beats; low: 8-bit |
| bus_ce_n | input | 1 | Observed chip enable, active low |
| bus_we_n | input | 1 | Observed write strobe, active low |
| bus_re_n | input | 1 | Observed read strobe, active low |
| bus_data | input | 16 | Observed data lines |
| ecc_value | output | 32 | Packed column and line parity |
| ecc_done | output | 1 | Page complete, result frozen |

## Verification
The bench builds the block with its default parameters: page sizes from 256 to 8192 bytes and a 32-bit result. This covers the largest page and the clamped size codes. Pages are driven in both bus widths and through both strobes, with deselected strobes and surplus beats mixed in. A syndrome helper in the bench confirms that one injected bit flip is located exactly and that two flips are flagged as uncorrectable.

// File: rtl/nes_pkg.sv
package nes_pkg;
  // Base-two log of the page size chosen by a size code, clamped to the largest page.
  function automatic int page_log(input logic [2:0] code, input int min_log, input int max_log);
    int span;
    span = max_log - min_log;
    return min_log + ((int'(code) > span) ? span : int'(code));
  endfunction
endpackage

// File: rtl/nes_strobe_detect.sv
module nes_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic re_n,
  output logic beat
);
  logic we_q, re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  // A strobe ends when it is first seen high after being low.
  assign beat = !ce_n && ((!we_q && we_n) || (!re_q && re_n));
endmodule

// File: rtl/nes_accum.sv
module nes_accum #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              beat,
  input  logic [15:0]       data,
  input  logic [ADDR_W:0]   limit,
  output logic [ADDR_W-1:0] line_even,
  output logic [ADDR_W-1:0] line_odd,
  output logic [7:0]        col_acc,
  output logic              done
);
  logic [ADDR_W:0]   cnt, cnt_nxt;
  logic [ADDR_W-1:0] le_nxt, lo_nxt, addr_lo, addr_hi;
  logic [7:0]        col_nxt;
  logic              par_lo, par_hi, take;

  assign done    = (cnt >= limit);
  assign take    = en && beat && !done;
  assign addr_lo = cnt[ADDR_W-1:0];
  assign addr_hi = addr_lo + ADDR_W'(1);
  assign par_lo  = ^data[7:0];
  assign par_hi  = ^data[15:8];

  always_comb begin
    le_nxt  = line_even;
    lo_nxt  = line_odd;
    col_nxt = col_acc ^ data[7:0];
    for (int k = 0; k < ADDR_W; k++) begin
      if (addr_lo[k]) lo_nxt[k] = lo_nxt[k] ^ par_lo;
      else            le_nxt[k] = le_nxt[k] ^ par_lo;
    end
    if (wide) begin
      col_nxt = col_nxt ^ data[15:8];
      for (int k = 0; k < ADDR_W; k++) begin
        if (addr_hi[k]) lo_nxt[k] = lo_nxt[k] ^ par_hi;
        else            le_nxt[k] = le_nxt[k] ^ par_hi;
      end
    end
    cnt_nxt = cnt + (wide ? (ADDR_W+1)'(2) : (ADDR_W+1)'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      line_even <= '0;
      line_odd  <= '0;
      col_acc   <= '0;
    end else if (!en) begin
      cnt       <= '0;
      line_even <= '0;
      line_odd  <= '0;
      col_acc   <= '0;
    end else if (take) begin
      cnt       <= cnt_nxt;
      line_even <= le_nxt;
      line_odd  <= lo_nxt;
      col_acc   <= col_nxt;
    end
  end
endmodule

// File: rtl/nes_pack.sv
module nes_pack #(
  parameter int ADDR_W = 13,
  parameter int ECC_W  = 2*ADDR_W + 6,
  parameter int LW     = $clog2(ADDR_W + 1)
) (
  input  logic [ADDR_W-1:0] line_even,
  input  logic [ADDR_W-1:0] line_odd,
  input  logic [7:0]        col_acc,
  input  logic [LW-1:0]     lg,
  output logic [ECC_W-1:0]  ecc
);
  always_comb begin
    ecc = '0;
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < 8; i++) begin
        if ((i >> j) & 1) ecc[2*j+1] = ecc[2*j+1] ^ col_acc[i];
        else              ecc[2*j]   = ecc[2*j]   ^ col_acc[i];
      end
    end
    for (int k = 0; k < ADDR_W; k++) begin
      if (k < int'(lg)) begin
        ecc[6+2*k] = line_even[k];
        ecc[7+2*k] = line_odd[k];
      end
    end
  end
endmodule

// File: rtl/nes_ecc_snoop.sv
module nes_ecc_snoop #(
  parameter int MIN_LOG = 8,
  parameter int ADDR_W  = 13,
  parameter int ECC_W   = 2*ADDR_W + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic [2:0]       ctl_size,
  input  logic             ctl_wide,
  input  logic             bus_ce_n,
  input  logic             bus_we_n,
  input  logic             bus_re_n,
  input  logic [15:0]      bus_data,
  output logic [ECC_W-1:0] ecc_value,
  output logic             ecc_done
);
  localparam int LW = $clog2(ADDR_W + 1);

  logic [LW-1:0]     lg;
  logic [ADDR_W:0]   limit;
  logic [ADDR_W-1:0] line_even, line_odd;
  logic [7:0]        col_acc;
  logic              beat, page_done;

  always_comb begin
    lg    = LW'(nes_pkg::page_log(ctl_size, MIN_LOG, ADDR_W));
    limit = (ADDR_W+1)'(1) << lg;
  end

  nes_strobe_detect u_strobe (
    .clk  (clk),
    .rst_n(rst_n),
    .ce_n (bus_ce_n),
    .we_n (bus_we_n),
    .re_n (bus_re_n),
    .beat (beat)
  );

  nes_accum #(.ADDR_W(ADDR_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_en),
    .wide     (ctl_wide),
    .beat     (beat),
    .data     (bus_data),
    .limit    (limit),
    .line_even(line_even),
    .line_odd (line_odd),
    .col_acc  (col_acc),
    .done     (page_done)
  );

  nes_pack #(.ADDR_W(ADDR_W), .ECC_W(ECC_W), .LW(LW)) u_pack (
    .line_even(line_even),
    .line_odd (line_odd),
    .col_acc  (col_acc),
    .lg       (lg),
    .ecc      (ecc_value)
  );

  assign ecc_done = ctl_en && page_done;
endmodule

// File: rtl/nes_ecc_checker.sv
module nes_ecc_checker #(
  parameter int MIN_LOG = 8,
  parameter int ECC_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_en,
  input logic [2:0]       ctl_size,
  input logic             bus_ce_n,
  input logic [ECC_W-1:0] ecc_value,
  input logic             ecc_done
);
  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (ecc_value == '0 && !ecc_done)); // R6

  AST_DESELECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce_n && ctl_en) |=> ($stable(ecc_value) || !$stable(ctl_size))); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_done && ctl_en) |=> (ecc_done || !ctl_en || !$stable(ctl_size))); // R4

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_done && ctl_en) |=> ($stable(ecc_value) || !ctl_en || !$stable(ctl_size))); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_size == 3'd0) |-> ((ecc_value >> (2*MIN_LOG + 6)) == '0)); // R3
endmodule

bind nes_ecc_snoop nes_ecc_checker #(.MIN_LOG(MIN_LOG), .ECC_W(ECC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_en   (ctl_en),
  .ctl_size (ctl_size),
  .bus_ce_n (bus_ce_n),
  .ecc_value(ecc_value),
  .ecc_done (ecc_done)
);

// File: tb/test_nes_ecc_snoop.sv
module test_nes_ecc_snoop;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0;
  logic [2:0]  ctl_size = 3'd0;
  logic        ctl_wide = 1'b0;
  logic        bus_ce_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic        bus_re_n = 1'b1;
  logic [15:0] bus_data = '0;
  logic [31:0] ecc_value;
  logic        ecc_done;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_ecc = '0;
  logic        done_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nes_ecc_snoop i_nes_ecc_snoop (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int a, input int seed);
    return 8'((a * 37) + (seed * 11) + ((a >> 3) * 5) + (a >> 8));
  endfunction

  function automatic logic [7:0] bus_byte(input int a, input int seed,
      input int fa, input int fb, input int fa2, input int fb2);
    logic [7:0] b;
    b = byte_of(a, seed);
    if (a == fa)  b[fb]  = ~b[fb];
    if (a == fa2) b[fb2] = ~b[fb2];
    return b;
  endfunction

  // Reference code for a page of 2^lg bytes, built from R7 and R8.
  function automatic logic [31:0] model(input int lg, input int seed,
      input int fa, input int fb, input int fa2, input int fb2);
    logic [12:0] le, lo;
    logic [7:0]  col, b;
    logic [31:0] r;
    le = '0; lo = '0; col = '0; r = '0;
    for (int a = 0; a < (1 << lg); a++) begin
      b = bus_byte(a, seed, fa, fb, fa2, fb2);
      col ^= b;
      for (int k = 0; k < lg; k++) begin
        if ((a >> k) & 1) lo[k] ^= ^b;
        else              le[k] ^= ^b;
      end
    end
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++) begin
        if ((i >> j) & 1) r[2*j+1] ^= col[i];
        else              r[2*j]   ^= col[i];
      end
    for (int k = 0; k < lg; k++) begin
      r[6+2*k] = le[k];
      r[7+2*k] = lo[k];
    end
    return r;
  endfunction

  // Syndrome helper (R10): 0 clean, 1 single correctable, 2 uncorrectable, 3 code bit only.
  function automatic int classify(input logic [31:0] stored, input logic [31:0] fresh,
      input int lg, output int addr, output int bitpos);
    logic [31:0] s;
    bit pairs_ok;
    s = stored ^ fresh;
    addr = 0; bitpos = 0;
    if (s == '0) return 0;
    pairs_ok = 1'b1;
    for (int p = 0; p < 3 + lg; p++)
      if (s[2*p] == s[2*p+1]) pairs_ok = 1'b0;
    if (pairs_ok) begin
      for (int j = 0; j < 3; j++)  bitpos |= int'(s[2*j+1]) << j;
      for (int k = 0; k < lg; k++) addr   |= int'(s[7+2*k]) << k;
      return 1;
    end
    if ($countones(s) == 1) return 3;
    return 2;
  endfunction

  task automatic one_beat(input logic [15:0] d, input bit use_read, input bit selected);
    @(negedge clk);
    bus_data = d;
    bus_ce_n = !selected;
    if (use_read) bus_re_n = 1'b0; else bus_we_n = 1'b0;
    @(negedge clk);
    bus_we_n = 1'b1;
    bus_re_n = 1'b1;
    @(negedge clk);
    bus_ce_n = 1'b1;
  endtask

  task automatic restart(input logic [2:0] code, input bit wide);
    @(negedge clk);
    ctl_en   = 1'b0;
    ctl_size = code;
    ctl_wide = wide;
    @(negedge clk);
    check(ecc_value == '0 && !ecc_done, "R6 clear on disable", ecc_value, '0);
    ctl_en = 1'b1;
  endtask

  // Driver: pushes the expected code, then plays the page on the bus.
  task automatic run_page(input logic [2:0] code, input bit wide, input bit use_read,
      input int seed, input bit noise, input int fa, input int fb, input int fa2, input int fb2);
    int lg, n, step;
    lg = (int'(code) > 5) ? 13 : 8 + int'(code);
    n = 1 << lg;
    step = wide ? 2 : 1;
    restart(code, wide);
    exp_q.push_back(model(lg, seed, fa, fb, fa2, fb2));
    for (int a = 0; a < n; a += step) begin
      if (noise && (a % 16 == 0)) one_beat(16'hA5C3 ^ 16'(a), use_read, 1'b0); // R2
      if (a == n - step) check(!ecc_done, "R4 done early", 32'(ecc_done), 32'd0);
      one_beat({wide ? bus_byte(a+1, seed, fa, fb, fa2, fb2) : 8'hFF,
                bus_byte(a, seed, fa, fb, fa2, fb2)}, use_read, 1'b1);
    end
    @(negedge clk);
    check(ecc_done, "R4 done after last beat", 32'(ecc_done), 32'd1);
  endtask

  // Monitor: compares each completed page against the scoreboard.
  always @(negedge clk) begin
    done_q <= ecc_done;
    if (ecc_done && !done_q) begin
      last_ecc <= ecc_value;
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected result", ecc_value, '0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(ecc_value == e, "R1/R7/R8 page code", ecc_value, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] good, held;
    int cls, ad, bp;
    repeat (3) @(negedge clk);
    check(ecc_value == '0 && !ecc_done, "R6 reset state", ecc_value, '0);
    rst_n = 1'b1;

    // R1 R7 R8: narrow writes, smallest page
    run_page(3'd0, 1'b0, 1'b0, 1, 1'b0, -1, 0, -1, 0);
    check(ecc_value[31:22] == '0, "R3 upper bits zero", ecc_value, ecc_value & 32'h003F_FFFF);
    good = ecc_value;

    // R5: surplus beats after done
    held = ecc_value;
    for (int i = 0; i < 4; i++) one_beat(16'h1234 * 16'(i + 1), 1'b0, 1'b1);
    @(negedge clk);
    check(ecc_value == held && ecc_done, "R5 frozen after done", ecc_value, held);

    // R9: wide beats through the read strobe
    run_page(3'd1, 1'b1, 1'b1, 2, 1'b0, -1, 0, -1, 0);
    // R2: deselected strobes mixed in
    run_page(3'd2, 1'b0, 1'b1, 3, 1'b1, -1, 0, -1, 0);
    run_page(3'd3, 1'b1, 1'b0, 4, 1'b1, -1, 0, -1, 0);
    // R3: clamped code selects the largest page
    run_page(3'd7, 1'b1, 1'b0, 5, 1'b0, -1, 0, -1, 0);

    // R10: single flip located, double flip flagged
    run_page(3'd0, 1'b0, 1'b0, 1, 1'b0, 173, 5, -1, 0);
    @(negedge clk);
    cls = classify(good, last_ecc, 8, ad, bp);
    check(cls == 1, "R10 single class", 32'(cls), 32'd1);
    check(ad == 173 && bp == 5, "R10 single location", 32'((ad << 3) | bp), 32'((173 << 3) | 5));
    run_page(3'd0, 1'b0, 1'b0, 1, 1'b0, 40, 2, 200, 7);
    @(negedge clk);
    cls = classify(good, last_ecc, 8, ad, bp);
    check(cls == 2, "R10 double class", 32'(cls), 32'd2);

    // R6: disable clears and restart gives zero before any beat
    restart(3'd0, 1'b0);
    @(negedge clk);
    check(ecc_value == '0 && !ecc_done, "R6 fresh start", ecc_value, '0);
    check(exp_q.size() == 0, "R4 every page completed", 32'(exp_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule